// File: doc/BRIEF.md
# Vector Slot Operand Field Extractor

This block pulls vector register indices and a multiply sub-operation code out of a 64-bit narrow instruction bundle. The bundle arrives as two 32-bit words. A slot-kind input says which slot is being decoded, and a form input picks the encoding within the multiply slot. The block returns the operand fields one clock later, marked by a valid flag. A later stage reads the register file with these indices.

The two slot kinds are a vector ALU slot, which has three register fields, and a multiply slot. The multiply slot has a three-register add encoding and a multiply encoding. The multiply encoding carries a 2-bit sub-operation code, one multiplicand register that stands for both sources, and a third register. Most fields are built from bundle bits that are not next to each other, and several of them take bits from both words. Each field is packed in rising bundle-bit order, so the lowest listed bundle bit becomes field bit 0.

Top module: `vslot_opx`

## Requirements
- R1: While reset is held and after it is released, before any strobe, valid_o is 0 and every field output is 0.
- R2: valid_o is 1 in the cycle after a cycle in which strobe_i was 1. It is 0 after a cycle in which strobe_i was 0.
- R3: With slot kind 0 (ALU), vs_o holds bundle bits 16..20. Bundle bit 16 goes to field bit 0.
- R4: With slot kind 0, vt_o holds bundle bits 22, 23, 25, 26 and 28. Bit 22 goes to field bit 0 and bit 28 to field bit 4.
- R5: With slot kind 0, vr_o holds bundle bits 29, 30, 31, 32 and 35, so it takes bits from both words. Bit 35 goes to field bit 4.
- R6: With slot kind 1 (multiply) and form 0 (add), vt_o holds bits 16..20, vs_o holds bits 41..45 (word1 bits 9..13), and vr_o holds bits 22, 23, 35, 36 and 37.
- R7: With slot kind 1 and form 1 (multiply), subop_o bit 0 is bundle bit 31 and bit 1 is bundle bit 32. mcand_o holds bits 16..20. third_o holds bits 22, 23, 35, 36 and 37, with bit 37 at field bit 4.
- R8: Outputs that the selected form does not use are 0. The multiply form zeroes vt_o, vs_o and vr_o. The ALU slot and the add form zero subop_o, mcand_o and third_o.
- R9: Bundle bits 0..3, which select the format, have no effect on any output. The same holds for every bundle bit outside the fields of the selected form.
- R10: While strobe_i is 0, every field output keeps its last captured value.
- R11: With slot kind 0, form_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous |
| strobe_i | input | 1 | Capture request for this cycle's bundle |
| bundle_lo_i | input | 32 | Bundle bits 31..0 |
| bundle_hi_i | input | 32 | Bundle bits 63..32 |
| slot_kind_i | input | 1 | 0 = vector ALU slot, 1 = multiply slot |
| form_i | input | 1 | Multiply slot form: 0 = add, 1 = multiply |
| valid_o | output | 1 | Fields captured in the previous cycle |
| vt_o | output | 5 | vt register index |
| vs_o | output | 5 | vs register index |
| vr_o | output | 5 | vr register index |
| subop_o | output | 2 | Multiply sub-operation code |
| mcand_o | output | 5 | Multiplicand register index |
| third_o | output | 5 | Multiply third register index |

## Verification
Assertions in the top module check the following on every cycle: the valid timing, the contiguous fields taken from one word (ALU vs, add-form vs), the sub-operation code that crosses the word boundary, the zeroing of unused outputs for each form, and the holding of outputs between strobes. The bench scenarios are needed for the scattered fields vt, vr and third. They compare every field against a bit-by-bit model over patterned bundles. They also use single-bit bundles to show where the highest field bits land. Finally, they cover the cases where something must have no effect: the format selector bits, the bits outside the fields, and the form input on the ALU slot.

// File: rtl/vslot_opx_pkg.sv
package vslot_opx_pkg;

    parameter int BUNDLE_W = 64;
    parameter int WORD_W   = 32;
    parameter int VREG_W   = 5;
    parameter int SUBOP_W  = 2;
    localparam int POS_W   = $clog2(BUNDLE_W);

    typedef enum logic {
        KIND_ALU = 1'b0,
        KIND_MUL = 1'b1
    } slot_kind_e;

    typedef enum logic {
        FORM_ADD  = 1'b0,
        FORM_MULT = 1'b1
    } mul_form_e;

    typedef struct packed {
        logic               valid;
        logic [VREG_W-1:0]  vt;
        logic [VREG_W-1:0]  vs;
        logic [VREG_W-1:0]  vr;
        logic [SUBOP_W-1:0] subop;
        logic [VREG_W-1:0]  mcand;
        logic [VREG_W-1:0]  third;
    } opx_state_t;

    // Position list for a 5-bit field, lowest bundle bit first.
    function automatic logic [5*POS_W-1:0] pos5(int p0, int p1, int p2, int p3, int p4);
        return {POS_W'(p4), POS_W'(p3), POS_W'(p2), POS_W'(p1), POS_W'(p0)};
    endfunction

    // Position list for a 2-bit field.
    function automatic logic [2*POS_W-1:0] pos2(int p0, int p1);
        return {POS_W'(p1), POS_W'(p0)};
    endfunction

endpackage

// File: rtl/vslot_opx_gather.sv
module vslot_opx_gather
    import vslot_opx_pkg::*;
#(
    parameter int                         FIELD_W  = 5,
    parameter logic [FIELD_W*POS_W-1:0]   POS_LIST = '0
) (
    input  logic [BUNDLE_W-1:0] bundle_i,
    output logic [FIELD_W-1:0]  field_o
);

    // One tap per field bit; the position list fixes the source bundle bit.
    for (genvar i = 0; i < FIELD_W; i++) begin : g_tap
        localparam logic [POS_W-1:0] SRC = POS_LIST[i*POS_W +: POS_W];
        assign field_o[i] = bundle_i[SRC];
    end

endmodule

// File: rtl/vslot_opx_alu.sv
module vslot_opx_alu
    import vslot_opx_pkg::*;
(
    input  logic [BUNDLE_W-1:0] bundle_i,
    output logic [VREG_W-1:0]   vt_o,
    output logic [VREG_W-1:0]   vs_o,
    output logic [VREG_W-1:0]   vr_o
);

    localparam logic [VREG_W*POS_W-1:0] VS_POS = pos5(16, 17, 18, 19, 20);
    localparam logic [VREG_W*POS_W-1:0] VT_POS = pos5(22, 23, 25, 26, 28);
    localparam logic [VREG_W*POS_W-1:0] VR_POS = pos5(29, 30, 31, 32, 35);

    vslot_opx_gather #(.FIELD_W(VREG_W), .POS_LIST(VS_POS)) u_vs (
        .bundle_i (bundle_i),
        .field_o  (vs_o)
    );

    vslot_opx_gather #(.FIELD_W(VREG_W), .POS_LIST(VT_POS)) u_vt (
        .bundle_i (bundle_i),
        .field_o  (vt_o)
    );

    vslot_opx_gather #(.FIELD_W(VREG_W), .POS_LIST(VR_POS)) u_vr (
        .bundle_i (bundle_i),
        .field_o  (vr_o)
    );

endmodule

// File: rtl/vslot_opx_mul.sv
module vslot_opx_mul
    import vslot_opx_pkg::*;
(
    input  logic [BUNDLE_W-1:0] bundle_i,
    output logic [VREG_W-1:0]   low_o,    // bits 16..20: add vt / multiplicand
    output logic [VREG_W-1:0]   high_o,   // bits 41..45: add vs
    output logic [VREG_W-1:0]   third_o,  // shared third register field
    output logic [SUBOP_W-1:0]  subop_o   // multiply sub-operation code
);

    localparam logic [VREG_W*POS_W-1:0]  LOW_POS   = pos5(16, 17, 18, 19, 20);
    localparam logic [VREG_W*POS_W-1:0]  HIGH_POS  = pos5(41, 42, 43, 44, 45);
    localparam logic [VREG_W*POS_W-1:0]  THIRD_POS = pos5(22, 23, 35, 36, 37);
    localparam logic [SUBOP_W*POS_W-1:0] SUB_POS   = pos2(31, 32);

    vslot_opx_gather #(.FIELD_W(VREG_W), .POS_LIST(LOW_POS)) u_low (
        .bundle_i (bundle_i),
        .field_o  (low_o)
    );

    vslot_opx_gather #(.FIELD_W(VREG_W), .POS_LIST(HIGH_POS)) u_high (
        .bundle_i (bundle_i),
        .field_o  (high_o)
    );

    vslot_opx_gather #(.FIELD_W(VREG_W), .POS_LIST(THIRD_POS)) u_third (
        .bundle_i (bundle_i),
        .field_o  (third_o)
    );

    vslot_opx_gather #(.FIELD_W(SUBOP_W), .POS_LIST(SUB_POS)) u_sub (
        .bundle_i (bundle_i),
        .field_o  (subop_o)
    );

endmodule

// File: rtl/vslot_opx.sv
module vslot_opx
    import vslot_opx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe_i,
    input  logic [WORD_W-1:0]   bundle_lo_i,
    input  logic [WORD_W-1:0]   bundle_hi_i,
    input  logic                slot_kind_i,
    input  logic                form_i,
    output logic                valid_o,
    output logic [VREG_W-1:0]   vt_o,
    output logic [VREG_W-1:0]   vs_o,
    output logic [VREG_W-1:0]   vr_o,
    output logic [SUBOP_W-1:0]  subop_o,
    output logic [VREG_W-1:0]   mcand_o,
    output logic [VREG_W-1:0]   third_o
);

    logic [BUNDLE_W-1:0] bundle;
    logic [VREG_W-1:0]   alu_vt, alu_vs, alu_vr;
    logic [VREG_W-1:0]   mul_low, mul_high, mul_third;
    logic [SUBOP_W-1:0]  mul_sub;
    slot_kind_e          kind;
    mul_form_e           form;
    opx_state_t          state_d, state_q;

    assign bundle = {bundle_hi_i, bundle_lo_i};
    assign kind   = slot_kind_e'(slot_kind_i);
    assign form   = mul_form_e'(form_i);

    vslot_opx_alu u_alu (
        .bundle_i (bundle),
        .vt_o     (alu_vt),
        .vs_o     (alu_vs),
        .vr_o     (alu_vr)
    );

    vslot_opx_mul u_mul (
        .bundle_i (bundle),
        .low_o    (mul_low),
        .high_o   (mul_high),
        .third_o  (mul_third),
        .subop_o  (mul_sub)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = strobe_i;
        if (strobe_i) begin
            state_d.vt    = '0;
            state_d.vs    = '0;
            state_d.vr    = '0;
            state_d.subop = '0;
            state_d.mcand = '0;
            state_d.third = '0;
            if (kind == KIND_ALU) begin
                state_d.vt = alu_vt;
                state_d.vs = alu_vs;
                state_d.vr = alu_vr;
            end else if (form == FORM_MULT) begin
                // Both multiply sources share the one multiplicand field.
                state_d.subop = mul_sub;
                state_d.mcand = mul_low;
                state_d.third = mul_third;
            end else begin
                state_d.vt = mul_low;
                state_d.vs = mul_high;
                state_d.vr = mul_third;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign valid_o = state_q.valid;
    assign vt_o    = state_q.vt;
    assign vs_o    = state_q.vs;
    assign vr_o    = state_q.vr;
    assign subop_o = state_q.subop;
    assign mcand_o = state_q.mcand;
    assign third_o = state_q.third;

    // R2
    valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> valid_o);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> !valid_o);

    // R3
    alu_vs_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && slot_kind_i == 1'b0) |=> vs_o == $past(bundle_lo_i[20:16]));

    // R6
    add_vs_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && slot_kind_i && !form_i) |=> vs_o == $past(bundle_hi_i[13:9]));

    // R7
    mult_subop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && slot_kind_i && form_i)
            |=> subop_o == {$past(bundle_hi_i[0]), $past(bundle_lo_i[31])});

    // R8
    mult_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && slot_kind_i && form_i)
            |=> (vt_o == '0 && vs_o == '0 && vr_o == '0));

    // R8
    three_reg_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !(slot_kind_i && form_i))
            |=> (subop_o == '0 && mcand_o == '0 && third_o == '0));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> ($stable(vt_o) && $stable(vs_o) && $stable(vr_o)
                       && $stable(subop_o) && $stable(mcand_o) && $stable(third_o)));

endmodule

// File: tb/vslot_opx_tb_top.sv
module vslot_opx_tb_top;

    localparam int NVEC = 8;
    // Packed vector: {kind, form, word1, word0}
    localparam logic [65:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b0, 1'b1, 32'h9ABC_DEF0, 32'h1234_5678},
        {1'b0, 1'b0, 32'h0000_0000, 32'h0001_0000},
        {1'b1, 1'b0, 32'h5A5A_5A5A, 32'hA5A5_A5A5},
        {1'b1, 1'b0, 32'h0000_3E00, 32'h0000_0000},
        {1'b1, 1'b1, 32'h0000_0001, 32'h8000_0000},
        {1'b1, 1'b1, 32'h3876_5432, 32'h0FED_CBA9},
        {1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
    };

    typedef struct packed {
        logic [4:0] vt, vs, vr;
        logic [1:0] sub;
        logic [4:0] mc, th;
    } fields_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [31:0] lo = '0, hi = '0;
    logic        kind = 1'b0, form = 1'b0;
    logic        valid;
    logic [4:0]  vt, vs, vr, mc, th;
    logic [1:0]  sub;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    vslot_opx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe),
        .bundle_lo_i (lo),
        .bundle_hi_i (hi),
        .slot_kind_i (kind),
        .form_i      (form),
        .valid_o     (valid),
        .vt_o        (vt),
        .vs_o        (vs),
        .vr_o        (vr),
        .subop_o     (sub),
        .mcand_o     (mc),
        .third_o     (th)
    );

    function automatic fields_t model(logic [31:0] w0, logic [31:0] w1, logic k, logic f);
        logic [63:0] b;
        fields_t     e;
        b = {w1, w0};
        e = '0;
        if (!k) begin
            e.vs = b[20:16];
            e.vt = {b[28], b[26], b[25], b[23], b[22]};
            e.vr = {b[35], b[32], b[31], b[30], b[29]};
        end else if (!f) begin
            e.vt = b[20:16];
            e.vs = b[45:41];
            e.vr = {b[37], b[36], b[35], b[23], b[22]};
        end else begin
            e.sub = {b[32], b[31]};
            e.mc  = b[20:16];
            e.th  = {b[37], b[36], b[35], b[23], b[22]};
        end
        return e;
    endfunction

    function automatic fields_t observed();
        fields_t o;
        o.vt = vt; o.vs = vs; o.vr = vr; o.sub = sub; o.mc = mc; o.th = th;
        return o;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic launch(logic [31:0] w0, logic [31:0] w1, logic k, logic f);
        @(negedge clk);
        lo = w0; hi = w1; kind = k; form = f; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic check_fields(fields_t e, logic k, logic f);
        if (!k) begin
            check("R3 alu vs", 32'(vs), 32'(e.vs));
            check("R4 alu vt", 32'(vt), 32'(e.vt));
            check("R5 alu vr", 32'(vr), 32'(e.vr));
            check("R8 alu unused", {20'd0, sub, mc, th}, {20'd0, e.sub, e.mc, e.th});
        end else if (!f) begin
            check("R6 add fields", {17'd0, vt, vs, vr}, {17'd0, e.vt, e.vs, e.vr});
            check("R8 add unused", {20'd0, sub, mc, th}, {20'd0, e.sub, e.mc, e.th});
        end else begin
            check("R7 mult fields", {20'd0, sub, mc, th}, {20'd0, e.sub, e.mc, e.th});
            check("R8 mult unused", {17'd0, vt, vs, vr}, {17'd0, e.vt, e.vs, e.vr});
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        fields_t a, b;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset", {5'd0, valid, vt, vs, vr, sub, mc, th}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {5'd0, valid, vt, vs, vr, sub, mc, th}, 32'd0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            launch(VEC[i][31:0], VEC[i][63:32], VEC[i][65], VEC[i][64]);
            check("R2 valid high", 32'(valid), 32'd1);
            check_fields(model(VEC[i][31:0], VEC[i][63:32], VEC[i][65], VEC[i][64]),
                         VEC[i][65], VEC[i][64]);
        end

        // R2 / R10: no strobe, inputs change, outputs hold
        a = observed();
        @(negedge clk);
        lo = 32'h1357_9BDF; hi = 32'h2468_ACE0; kind = 1'b0; form = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R2 valid low", 32'(valid), 32'd0);
        check("R10 hold", 32'(observed()), 32'(a));

        // R5: bundle bit 35 lands at vr bit 4
        launch(32'h0, 32'h0000_0008, 1'b0, 1'b0);
        check("R5 bit35", 32'(vr), 32'd16);
        // R4: bundle bit 28 lands at vt bit 4
        launch(32'h1000_0000, 32'h0, 1'b0, 1'b0);
        check("R4 bit28", 32'(vt), 32'd16);
        // R7: bit 31 -> subop bit 0, bit 32 -> subop bit 1, bit 37 -> third bit 4
        launch(32'h8000_0000, 32'h0, 1'b1, 1'b1);
        check("R7 subop bit31", 32'(sub), 32'd1);
        launch(32'h0, 32'h0000_0021, 1'b1, 1'b1);
        check("R7 subop bit32", 32'(sub), 32'd2);
        check("R7 third bit37", 32'(th), 32'd16);

        // R9: every bit outside the ALU fields set, including bits 0..3
        launch(32'h0920_FFFF, 32'hFFFF_FFF6, 1'b0, 1'b0);
        check("R9 outside bits", 32'(observed()), 32'd0);
        // R9: format selector bits do not disturb fields
        launch(32'h1234_5670, 32'h9ABC_DEF0, 1'b1, 1'b0);
        a = observed();
        launch(32'h1234_567F, 32'h9ABC_DEF0, 1'b1, 1'b0);
        check("R9 selector bits", 32'(observed()), 32'(a));

        // R11: form ignored on ALU slot
        launch(32'hC3A5_9E71, 32'h0000_002F, 1'b0, 1'b0);
        a = observed();
        launch(32'hC3A5_9E71, 32'h0000_002F, 1'b0, 1'b1);
        b = observed();
        check("R11 form ignored", 32'(b), 32'(a));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule